// File: doc/BRIEF.md
# Frame Phase Meter

This block measures where a recovered 8 kHz reference edge lands inside a local serial frame of 256 bit times (32 channels of 8 bits). A free-running bit counter is zeroed by the local frame pulse. Each rising edge of the reference captures the current bit index, so the captured value is the offset of the reference from the start of the frame.

The 8-bit offset is reported as a channel number in the upper five bits and a bit number in the lower three bits. A ninth bit records drift across the frame boundary. It toggles whenever successive readings jump by more than half a frame, which means the phase has wrapped past either end of the frame. The ninth bit therefore acts as the most significant bit of an extended phase count, and a user can follow the reference drifting in either direction.

The word is held in a register and changes only when a new capture arrives. A one-cycle valid pulse marks each capture. When the reference runs at the frame rate, this gives one update per frame.

Top module: `frame_phase_meter`

## Requirements
- R1: While reset is asserted and after it is released, `phase_o` is 0 and `valid_o` is 0 until the first capture.
- R2: The captured position equals the number of bit clocks elapsed since the bit in which `fp_i` was high. That bit counts as position 0. `phase_o[7:3]` holds the channel and `phase_o[2:0]` holds the bit within the channel.
- R3: A capture happens at the clock edge that first samples `ref_i` high after sampling it low. `phase_o` takes the new value at that edge, and `valid_o` is high for exactly the following cycle.
- R4: A reference that stays high, or stays low, causes no capture and leaves `phase_o` unchanged.
- R5: The first capture after reset never changes `phase_o[8]`.
- R6: If the new position is smaller than the previous one by more than 128, `phase_o[8]` toggles (forward wrap past channel 31 bit 7).
- R7: If the new position is larger than the previous one by more than 128, `phase_o[8]` toggles (backward wrap below channel 0 bit 0).
- R8: A change of 128 or less in either direction leaves `phase_o[8]` unchanged.
- R9: Without a frame pulse, the bit counter keeps running and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_i | input | 1 | Local frame pulse; marks bit 0 of the frame |
| ref_i | input | 1 | Recovered 8 kHz reference |
| phase_o | output | 9 | {wrap bit, channel[4:0], bit[2:0]} |
| valid_o | output | 1 | One-cycle pulse after each capture |

## Verification
The hardest situation to reach from the ports is a jump of exactly half a frame, on either side of a wrap. The wrap bit must hold at a difference of exactly 128 and toggle at 129 and beyond. The stimulus places reference edges at chosen bit offsets in consecutive frames: 20 to 200, 200 to 72, 250 to 3 and 3 to 131. Each step lands on a chosen side of the threshold. A long segment with no frame pulse reaches the counter rollover, and a reference held high across a whole frame exercises the edge-only capture rule.

// File: rtl/frame_phase_meter.sv
module frame_phase_meter #(
  parameter int CH_W  = 5,
  parameter int BIT_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fp_i,
  input  logic                  ref_i,
  output logic [CH_W+BIT_W:0]   phase_o,
  output logic                  valid_o
);
  localparam int POS_W = CH_W + BIT_W;
  localparam logic [POS_W-1:0] HALF = POS_W'(1) << (POS_W - 1);

  logic [POS_W-1:0] cnt_q, cnt_nxt, last_q;
  logic             ref_q, seen_q, wrap_q;
  logic             rise, fwd_wrap, bwd_wrap;

  assign cnt_nxt  = fp_i ? '0 : cnt_q + POS_W'(1);
  assign rise     = ref_i & ~ref_q;
  assign fwd_wrap = seen_q && (last_q > cnt_nxt) && ((last_q - cnt_nxt) > HALF);
  assign bwd_wrap = seen_q && (cnt_nxt > last_q) && ((cnt_nxt - last_q) > HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ref_q   <= 1'b0;
      last_q  <= '0;
      seen_q  <= 1'b0;
      wrap_q  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      ref_q   <= ref_i;
      valid_o <= rise;
      if (rise) begin
        last_q <= cnt_nxt;
        seen_q <= 1'b1;
        wrap_q <= wrap_q ^ (fwd_wrap | bwd_wrap);
      end
    end
  end

  assign phase_o = {wrap_q, last_q};
endmodule

module frame_phase_meter_chk #(
  parameter int CH_W  = 5,
  parameter int BIT_W = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fp_i,
  input logic                ref_i,
  input logic [CH_W+BIT_W:0] phase_o,
  input logic                valid_o
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r3_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(ref_i) && !$past(ref_i, 2)));
  a_r4_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(phase_o));
  a_r2_zero_on_fp: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(fp_i)) |-> (phase_o[CH_W+BIT_W-1:0] == '0));
  a_r6_wrap_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_o[CH_W+BIT_W]) |-> valid_o);
endmodule

bind frame_phase_meter frame_phase_meter_chk #(.CH_W(CH_W), .BIT_W(BIT_W)) chk_i (.*);

// File: tb/frame_phase_meter_tb_top.sv
module frame_phase_meter_tb_top;
  logic       clk = 0, rst_n = 0, fp_i = 0, ref_i = 0;
  logic [8:0] phase_o;
  logic       valid_o;
  int checks = 0, errors = 0, vcount = 0;
  bit done = 0;
  logic [8:0] expq[$];
  logic [7:0] prev_pos = 0;
  bit have_prev = 0, wrap = 0;

  always #5 clk = ~clk;

  frame_phase_meter dut_i (.clk(clk), .rst_n(rst_n), .fp_i(fp_i), .ref_i(ref_i),
                           .phase_o(phase_o), .valid_o(valid_o));

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void push(logic [7:0] pos);
    if (have_prev && prev_pos > pos && (prev_pos - pos) > 128) wrap = ~wrap;
    if (have_prev && pos > prev_pos && (pos - prev_pos) > 128) wrap = ~wrap;
    have_prev = 1;
    prev_pos = pos;
    expq.push_back({wrap, pos});
  endfunction

  task automatic seg(int len, bit fp0, int rise_at, bit level, logic [7:0] exp_pos);
    if (rise_at >= 0) push(exp_pos);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      fp_i  = fp0 && (b == 0);
      ref_i = (rise_at < 0) ? level : (level ? (b >= rise_at) : (b == rise_at));
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (valid_o) begin
        vcount++;
        if (expq.size() == 0) check("R3 unexpected capture", phase_o, 9'h1ff);
        else check("R2/R6/R7/R8 capture", phase_o, expq.pop_front());
      end
    end
  end

  initial begin
    int snap;
    logic [8:0] ph;
    repeat (3) @(negedge clk);
    check("R1 reset phase", phase_o, 9'h000);
    check("R1 reset valid", {8'h0, valid_o}, 9'h000);
    rst_n = 1;
    seg(256, 1, -1, 0, 0);
    check("R1 no capture idle", phase_o, 9'h000);
    seg(256, 1, 10, 0, 10);    // R5 first capture, wrap stays 0
    seg(256, 1, 20, 0, 20);
    seg(256, 1, 200, 0, 200);  // R7 +180 toggles
    seg(256, 1, 72, 0, 72);    // R8 -128 holds
    seg(256, 1, 250, 0, 250);  // R7 +178 toggles
    seg(256, 1, 3, 0, 3);      // R6 -247 toggles
    seg(256, 1, 131, 0, 131);  // R8 +128 holds
    seg(256, 1, 0, 0, 0);      // R2 capture in fp bit, -131 toggles (R6)
    seg(256, 1, 197, 0, 197);  // R2 channel 24 bit 5; R7 +197 toggles
    seg(256, 1, 5, 1, 5);      // R4 rises once, stays high
    snap = vcount; ph = phase_o;
    seg(256, 1, -1, 1, 0);     // R4 held high across frame
    seg(10, 1, -1, 0, 0);
    check("R4 no capture when held", vcount[8:0], snap[8:0]);
    check("R4 phase unchanged", phase_o, ph);
    seg(256, 1, -1, 0, 0);     // R9 fp at bit 0 only
    seg(300, 0, 44, 0, 44);    // R9 counter rolls 255->0, 256+44
    seg(4, 1, -1, 0, 0);
    check("R3 all expected captures seen", 9'(expq.size()), 9'd0);
    check("R3 capture count", vcount[8:0], 9'd11);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule